// File: doc/BRIEF.md
# Sector Erase Command Window Timer

This block sits on the device side of a flash memory, behind the bus command decoder. It collects sector erase commands into one batch. The first sector erase command opens an acceptance window, and each further sector erase command that arrives inside the window adds its sector to the batch and restarts the full window. While the window is open, the status bit `dq3` reads 0. The host may keep adding sectors during this time. A host that sends each command within one window length of the last one never needs to poll the bit.

When a full window passes with no new sector erase command, `dq3` goes to 1 and the block emits a one-cycle `erase_start` pulse. From then on, every command except erase suspend is locked out until the erase engine reports completion on `erase_done`. Each locked-out command produces a one-cycle `cmd_ignored` pulse.

A chip erase command skips the window entirely. The erase engine itself is outside this block.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `dq3`, `sector_mask`, `erase_start` and `cmd_ignored` are all 0.
- R2: `cmd_kind` encodes the command as 01 sector erase, 10 chip erase, 11 erase suspend and 00 any other command. A sector erase command (`cmd_valid` with `cmd_kind`=01) seen while `dq3`=0 sets bit `cmd_sector` of `sector_mask` from the next cycle on. It also leaves `dq3` at 0.
- R3: The window length is W = CLK_KHZ*WINDOW_US/1000 clock cycles, with a minimum of 1. `dq3` rises W clock edges after the edge that accepted the last sector erase command, and `erase_start` is 1 in exactly that first cycle.
- R4: Each sector erase command accepted while the window is open restarts the full W-cycle count. This holds even when it arrives on the edge where the window would have closed.
- R5: A chip erase command while idle (`dq3`=0 and `sector_mask`=0) opens no window. On the next cycle `dq3` is 1, every bit of `sector_mask` is 1, and `erase_start` pulses.
- R6: While `dq3`=1, any command other than erase suspend leaves `sector_mask` and `dq3` unchanged and raises `cmd_ignored` for the following cycle. Erase suspend raises no `cmd_ignored`.
- R7: `erase_done` clears `sector_mask` and `dq3` on the next cycle, from any state. It takes priority over a command presented in the same cycle.
- R8: While the window is open, chip erase, erase suspend and other commands change neither the mask nor the remaining window count, and raise no `cmd_ignored`.
- R9: While idle, other and erase suspend commands have no effect on any output.
- R10: `erase_start` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_kind | input | 2 | Command code: 00 other, 01 sector erase, 10 chip erase, 11 erase suspend |
| cmd_sector | input | $clog2(NUM_SECTORS) | Sector number for a sector erase command |
| erase_done | input | 1 | Completion pulse from the erase engine |
| dq3 | output | 1 | Window status: 0 while commands are accepted, 1 once the erase has begun |
| sector_mask | output | NUM_SECTORS | Sectors selected for the batched erase |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| cmd_ignored | output | 1 | One-cycle pulse for a command dropped during lockout |

## Verification
A wrong remaining count in the window timer shows up as a `dq3` rise and an `erase_start` pulse that come a cycle or more early or late. This is visible within W cycles of the last sector command.

A wrong state shows up on the very next cycle. Depending on the fault, it can appear in three ways:
- a `cmd_ignored` pulse that is missing or spurious;
- a mask bit that changes during lockout;
- `dq3` staying high after `erase_done`.

The bench mirrors all outputs with a behavioural model every cycle. It also measures the window length directly after single, retriggered and edge-of-window commands.

// File: rtl/sew_pkg.sv
package sew_pkg;

  typedef enum logic [1:0] {
    CMD_OTHER   = 2'b00,
    CMD_SECTOR  = 2'b01,
    CMD_CHIP    = 2'b10,
    CMD_SUSPEND = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_WINDOW = 2'b01,
    ST_BUSY   = 2'b10
  } state_e;

  // Number of clock cycles in the acceptance window, never below one.
  function automatic int unsigned window_cycles(int unsigned clk_khz, int unsigned win_us);
    int unsigned c;
    c = (clk_khz * win_us) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
  parameter int unsigned CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] count;
  logic          running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (clear) begin
      running <= 1'b0;
      count   <= '0;
    end else if (load) begin
      running <= 1'b1;
      count   <= CW'(CYCLES - 1);
    end else if (running) begin
      if (count == '0) running <= 1'b0;
      else             count   <= count - 1'b1;
    end
  end

  // A reload on the closing edge wins over the close.
  assign expired = running && (count == '0) && !load && !clear;

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count < CW'(CYCLES)));

  assert_idle_after_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !running);

endmodule

// File: rtl/sew_mask.sv
module sew_mask #(
  parameter int unsigned NUM_SECTORS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_one,
  input  logic [((NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1)-1:0] sel,
  input  logic                   set_all,
  input  logic                   clear,
  output logic [NUM_SECTORS-1:0] mask
);
  localparam int unsigned SW = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

  logic [NUM_SECTORS-1:0] hit;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    assign hit[i] = set_one && (sel == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask[i] <= 1'b0;
      else if (clear)   mask[i] <= 1'b0;
      else if (set_all) mask[i] <= 1'b1;
      else if (hit[i])  mask[i] <= 1'b1;
    end
  end

  assert_single_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));

endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       erase_done,
  input  logic       expired,
  output logic       accept_sector,
  output logic       accept_chip,
  output logic       lock_hit,
  output logic       dq3,
  output logic       erase_start,
  output logic       cmd_ignored
);
  state_e state, state_nx;
  cmd_e   kind;

  assign kind = cmd_e'(cmd_kind);

  assign accept_sector = cmd_valid && (kind == CMD_SECTOR) && (state != ST_BUSY) && !erase_done;
  assign accept_chip   = cmd_valid && (kind == CMD_CHIP) && (state == ST_IDLE) && !erase_done;
  assign lock_hit      = cmd_valid && (kind != CMD_SUSPEND) && (state == ST_BUSY) && !erase_done;

  always_comb begin
    state_nx = state;
    if (erase_done)          state_nx = ST_IDLE;
    else if (accept_sector)  state_nx = ST_WINDOW;
    else if (accept_chip)    state_nx = ST_BUSY;
    else if (expired)        state_nx = ST_BUSY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      erase_start <= 1'b0;
      cmd_ignored <= 1'b0;
    end else begin
      state       <= state_nx;
      erase_start <= accept_chip || expired;
      cmd_ignored <= lock_hit;
    end
  end

  assign dq3 = (state == ST_BUSY);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  assert_close_only_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> (state == ST_WINDOW));

endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned WINDOW_US   = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [((NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1)-1:0] cmd_sector,
  input  logic                   erase_done,
  output logic                   dq3,
  output logic [NUM_SECTORS-1:0] sector_mask,
  output logic                   erase_start,
  output logic                   cmd_ignored
);
  localparam int unsigned WIN = sew_pkg::window_cycles(CLK_KHZ, WINDOW_US);

  logic accept_sector, accept_chip, lock_hit, expired;

  sew_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .erase_done(erase_done), .expired(expired),
    .accept_sector(accept_sector), .accept_chip(accept_chip), .lock_hit(lock_hit),
    .dq3(dq3), .erase_start(erase_start), .cmd_ignored(cmd_ignored)
  );

  sew_timer #(.CYCLES(WIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept_sector), .clear(erase_done),
    .expired(expired)
  );

  sew_mask #(.NUM_SECTORS(NUM_SECTORS)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_one(accept_sector), .sel(cmd_sector),
    .set_all(accept_chip), .clear(erase_done), .mask(sector_mask)
  );

  assert_ignore_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dq3 && cmd_kind != 2'b11 && !erase_done) |=> (cmd_ignored && dq3 && $stable(sector_mask)));

  assert_suspend_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dq3 && cmd_kind == 2'b11 && !erase_done) |=> !cmd_ignored);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> (!dq3 && sector_mask == '0));

  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_start_with_dq3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq3) |-> erase_start);

endmodule

// File: tb/sector_erase_window_tb.sv
module sector_erase_window_tb;
  localparam int N   = 8;
  localparam int KHZ = 200;
  localparam int WUS = 50;
  localparam int W   = (KHZ * WUS / 1000 < 1) ? 1 : KHZ * WUS / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [2:0] cmd_sector = 3'd0;
  logic erase_done = 1'b0;
  logic dq3, erase_start, cmd_ignored;
  logic [N-1:0] sector_mask;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  sector_erase_window #(.NUM_SECTORS(N), .CLK_KHZ(KHZ), .WINDOW_US(WUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .erase_done(erase_done), .dq3(dq3),
    .sector_mask(sector_mask), .erase_start(erase_start), .cmd_ignored(cmd_ignored)
  );

  always #10 clk = ~clk;

  // Behavioural reference: 0 idle, 1 collecting, 2 erasing.
  int m_phase = 0;
  int m_left = 0;
  int m_mask = 0;
  int m_start = 0;
  int m_ign = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_mask = 0; m_start = 0; m_ign = 0;
    end else begin
      m_start = 0; m_ign = 0;
      if (erase_done) begin
        m_phase = 0; m_mask = 0;
      end else if (m_phase == 2) begin
        if (cmd_valid && cmd_kind != 2'b11) m_ign = 1;
      end else if (cmd_valid && cmd_kind == 2'b01) begin
        m_mask = m_mask | (1 << cmd_sector);
        m_phase = 1; m_left = W;
      end else if (m_phase == 0 && cmd_valid && cmd_kind == 2'b10) begin
        m_mask = (1 << N) - 1; m_phase = 2; m_start = 1;
      end else if (m_phase == 1) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_phase = 2; m_start = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(dq3 == (m_phase == 2), {cur_req, " dq3"}, int'(dq3), int'(m_phase == 2));
    chk(int'(sector_mask) == m_mask, {cur_req, " mask"}, int'(sector_mask), m_mask);
    chk(int'(erase_start) == m_start, {cur_req, " start"}, int'(erase_start), m_start);
    chk(int'(cmd_ignored) == m_ign, {cur_req, " ignored"}, int'(cmd_ignored), m_ign);
  end

  task automatic send(input logic [1:0] k, input int s);
    cmd_valid = 1'b1; cmd_kind = k; cmd_sector = 3'(s);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'b00; cmd_sector = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic done_pulse;
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  // Edges from the last command to the dq3 rise.
  task automatic measure(input string req, input int exp);
    int k = 0;
    while (!dq3 && k < 200) begin
      @(negedge clk); k++;
    end
    chk(k == exp, {req, " window length"}, k, exp);
    chk(erase_start == 1'b1, {req, " start at rise"}, int'(erase_start), 1);
  endtask

  initial begin
    idle(2);
    cur_req = "R1";
    chk(dq3 == 0 && sector_mask == 0 && !erase_start && !cmd_ignored, "R1 reset", int'(sector_mask), 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    send(2'b01, 3);
    chk(sector_mask == 8'h08 && !dq3, "R2 bit set", int'(sector_mask), 8);
    cur_req = "R3";
    measure("R3", W);
    idle(1);
    chk(!erase_start, "R10 pulse single", int'(erase_start), 0);

    cur_req = "R6";
    send(2'b00, 0);
    chk(cmd_ignored == 1, "R6 other ignored", int'(cmd_ignored), 1);
    send(2'b10, 0);
    send(2'b01, 5);
    chk(sector_mask == 8'h08, "R6 mask held", int'(sector_mask), 8);
    send(2'b11, 0);
    chk(cmd_ignored == 0, "R6 suspend passes", int'(cmd_ignored), 0);
    idle(2);

    cur_req = "R7";
    done_pulse();
    chk(!dq3 && sector_mask == 0, "R7 cleared", int'(sector_mask), 0);
    idle(2);

    cur_req = "R4";
    send(2'b01, 1);
    idle(5);
    send(2'b01, 6);
    idle(W - 3);
    send(2'b01, 0);
    measure("R4", W);
    chk(sector_mask == 8'h43, "R4 batch mask", int'(sector_mask), 8'h43);
    done_pulse();
    idle(2);

    cur_req = "R8";
    send(2'b01, 2);
    send(2'b10, 0);
    send(2'b11, 0);
    send(2'b00, 0);
    measure("R8", W - 3);
    chk(sector_mask == 8'h04, "R8 mask only sector", int'(sector_mask), 4);
    done_pulse();
    idle(2);

    cur_req = "R9";
    send(2'b00, 4);
    send(2'b11, 4);
    idle(3);
    chk(!dq3 && sector_mask == 0, "R9 idle no effect", int'(sector_mask), 0);

    cur_req = "R5";
    send(2'b10, 0);
    chk(dq3 && sector_mask == 8'hFF && erase_start, "R5 chip erase", int'(sector_mask), 255);
    idle(3);

    cur_req = "R7";
    erase_done = 1'b1; cmd_valid = 1'b1; cmd_kind = 2'b01; cmd_sector = 3'd7;
    @(negedge clk);
    erase_done = 1'b0; cmd_valid = 1'b0; cmd_kind = 2'b00;
    chk(!dq3 && sector_mask == 0 && !cmd_ignored, "R7 done priority", int'(sector_mask), 0);
    idle(2);

    cur_req = "R4";
    send(2'b01, 4);
    idle(W - 1);
    send(2'b01, 5);
    measure("R4 edge retrigger", W);
    done_pulse();

    cur_req = "R7";
    send(2'b01, 3);
    idle(2);
    done_pulse();
    idle(W + 2);
    chk(!dq3 && sector_mask == 0, "R7 abort window", int'(dq3), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule